// File: doc/BRIEF.md
# Random Generator Control and Output Buffer

This block sits between a conditioned entropy stream and a simple register bus. Conditioned words arrive on a valid/data input from an external stage. When the generator is running, the block collects them into two four-word stages. Software sees three registers: control, status and data. It polls the ready flag, or waits for the interrupt, and then reads the data register. Each read returns one stored word and consumes it. When the rear stage is already full as the front stage drains, eight words can be read for one ready event.

A small sequencer tracks the generator's lifecycle. Its states are:
- OFF: the generator is disabled.
- CRST: conditioning reset is held.
- INIT: a fixed-length reinitialisation.
- RUN: entropy is accepted only in this state.

Its transitions are:
- OFF to INIT when enable is set with conditioning-reset clear.
- Any state to CRST while the conditioning-reset bit is set.
- CRST to INIT or to OFF when that bit is released, depending on enable.
- INIT to RUN when the init counter expires.
- INIT or RUN to OFF when enable is cleared.

A soft reset takes two writes: first enable=0 with conditioning-reset=1, then enable=1 with conditioning-reset=0. A lock bit freezes the configuration fields until a hardware reset. Health-test failures arrive on two error pins. They set sticky flags, flush the buffers and block data reads.

Top module: `rng_ctrl`

## Requirements
- R1: After hardware reset the control and status registers read 0, `irq` is low and a data-register read returns 0.
- R2: The control register (address 0) holds these fields, and a write reads back unchanged while the lock bit is clear:
  - bit 0: enable
  - bit 1: interrupt enable
  - bit 2: conditioning reset
  - bit 3: lock
  - bits 7:4: clock divider
- R3: Entropy words are taken only in RUN, which is entered INIT_CYCLES cycles after the INIT state begins. Words offered in OFF, CRST or INIT are discarded.
- R4: Status bit 0 (ready) is set once four words are buffered. Reads of the data register (address 2) return them in arrival order, one word per read.
- R5: When the rear stage holds four words as the fourth read drains the front stage, ready stays high and four more words follow in order. Words offered while both stages are full are dropped.
- R6: A data read while ready is low or either error flag is set returns 0.
- R7: A pulse on `clk_err_in` or `seed_err_in` sets status bit 1 or bit 2 respectively, and flushes both stages. A flag stays set until a status write (address 1) puts 0 in its bit; writing 1 leaves it set.
- R8: `irq` is high exactly when interrupt enable is set and either ready or an error flag is set.
- R9: While conditioning reset is set, both stages are empty and entropy is discarded. Divider and other configuration bits written in the same write take effect. Data flows again after the second write and reinitialisation.
- R10: While lock is set, writes to interrupt enable, lock and divider are ignored, but enable and conditioning reset still respond. A soft reset keeps the locked values, and only hardware reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, valid in the cycle of the access |
| ent_valid | input | 1 | Conditioned word present |
| ent_data | input | WORD_W | Conditioned word |
| seed_err_in | input | 1 | Seed health failure pulse |
| clk_err_in | input | 1 | Clock health failure pulse |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions assume that `seed_err_in` and `clk_err_in` arrive as single-cycle pulses, not held levels. They also assume that a status write and an error pulse never fall in the same cycle; the stickiness check depends on this. The bench drives every bus access and entropy word for exactly one cycle, pulses each error pin once, and spaces error pulses away from status writes. Bus inputs change only on the falling clock edge, so each access is seen by exactly one rising edge.

// File: rtl/rng_pkg.sv
package rng_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_CRST = 2'd1,
        ST_INIT = 2'd2,
        ST_RUN  = 2'd3
    } rng_state_e;

    localparam int unsigned DIV_W = 4;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // control register image, enable in bit 0
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             lock;
        logic             crst;
        logic             ie;
        logic             en;
    } ctrl_t;
endpackage

// File: rtl/rng_seq.sv
module rng_seq
    import rng_pkg::*;
#(
    parameter int unsigned INIT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       crst,
    output rng_state_e state,
    output logic       accept,
    output logic       flush
);
    localparam int unsigned IC_W = $clog2(INIT_CYCLES + 1);
    localparam logic [IC_W-1:0] LAST = IC_W'(INIT_CYCLES - 1);

    rng_state_e state_q, state_d;
    logic [IC_W-1:0] init_cnt;
    logic init_done;

    assign init_done = (init_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 init_cnt <= '0;
        else if (state_q != ST_INIT) init_cnt <= '0;
        else if (!init_done)        init_cnt <= init_cnt + IC_W'(1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (crst)    state_d = ST_CRST;
                else if (en) state_d = ST_INIT;
            end
            ST_CRST: begin
                if (!crst)   state_d = en ? ST_INIT : ST_OFF;
            end
            ST_INIT: begin
                if (crst)           state_d = ST_CRST;
                else if (!en)       state_d = ST_OFF;
                else if (init_done) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (crst)     state_d = ST_CRST;
                else if (!en) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        state  = state_q;
        accept = (state_q == ST_RUN) && !crst;
        flush  = crst || (state_q == ST_CRST);
    end
endmodule

// File: rtl/rng_obuf.sv
module rng_obuf #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              pop,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic [$clog2(DEPTH+1)-1:0] front_lvl
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [WORD_W-1:0] front [DEPTH];
    logic [WORD_W-1:0] back  [DEPTH];
    logic [CW-1:0] front_cnt, back_cnt, front_after;
    logic [IW-1:0] rd_idx, wr_idx;
    logic pop_ok, move, take;

    assign pop_ok      = pop && (front_cnt != '0);
    assign front_after = front_cnt - CW'(pop_ok);
    assign move        = (front_after == '0) && (back_cnt == FULL);
    assign take        = in_valid && (move || (back_cnt != FULL));
    assign wr_idx      = move ? '0 : back_cnt[IW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            front_cnt <= '0;
            back_cnt  <= '0;
            rd_idx    <= '0;
        end else if (flush) begin
            front_cnt <= '0;
            back_cnt  <= '0;
            rd_idx    <= '0;
        end else if (move) begin
            front_cnt <= FULL;
            back_cnt  <= CW'(take);
            rd_idx    <= '0;
        end else begin
            front_cnt <= front_after;
            back_cnt  <= back_cnt + CW'(take);
            rd_idx    <= rd_idx + IW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!flush && move) begin
            for (int i = 0; i < int'(DEPTH); i++) front[i] <= back[i];
        end
        if (!flush && take) back[wr_idx] <= in_data;
    end

    assign out_valid = (front_cnt != '0);
    assign out_data  = front[rd_idx];
    assign front_lvl = front_cnt;
endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
    import rng_pkg::*;
#(
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned INIT_CYCLES = 16,
    parameter int unsigned BUF_DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              ent_valid,
    input  logic [WORD_W-1:0] ent_data,
    input  logic              seed_err_in,
    input  logic              clk_err_in,
    output logic              irq
);
    localparam int unsigned CTRL_W = $bits(ctrl_t);
    localparam int unsigned LVL_W  = $clog2(BUF_DEPTH + 1);

    ctrl_t ctrl_q, wr_ctrl;
    logic seed_err_q, clk_err_q, any_err;
    logic ctrl_wr, stat_wr, data_rd, read_ok;
    logic drdy, seq_accept, seq_flush, buf_flush;
    logic [WORD_W-1:0] buf_data;
    logic [LVL_W-1:0]  front_lvl;
    rng_state_e state;
    logic unused_wdata;

    assign wr_ctrl      = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign unused_wdata = ^bus_wdata[WORD_W-1:CTRL_W];
    assign ctrl_wr  = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
    assign stat_wr  = bus_sel && bus_wr && (bus_addr == ADDR_STAT);
    assign data_rd  = bus_sel && !bus_wr && (bus_addr == ADDR_DATA);
    assign any_err  = seed_err_q || clk_err_q;
    assign read_ok  = data_rd && drdy && !any_err;
    assign buf_flush = seq_flush || seed_err_in || clk_err_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.en   <= wr_ctrl.en;
            ctrl_q.crst <= wr_ctrl.crst;
            if (!ctrl_q.lock) begin
                ctrl_q.ie   <= wr_ctrl.ie;
                ctrl_q.lock <= wr_ctrl.lock;
                ctrl_q.div  <= wr_ctrl.div;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_err_q <= 1'b0;
            clk_err_q  <= 1'b0;
        end else begin
            if (seed_err_in)  seed_err_q <= 1'b1;
            else if (stat_wr) seed_err_q <= seed_err_q & bus_wdata[2];
            if (clk_err_in)   clk_err_q  <= 1'b1;
            else if (stat_wr) clk_err_q  <= clk_err_q & bus_wdata[1];
        end
    end

    rng_seq #(.INIT_CYCLES(INIT_CYCLES)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl_q.en),
        .crst   (ctrl_q.crst),
        .state  (state),
        .accept (seq_accept),
        .flush  (seq_flush)
    );

    rng_obuf #(.WORD_W(WORD_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (buf_flush),
        .in_valid  (ent_valid && seq_accept && !any_err),
        .in_data   (ent_data),
        .pop       (read_ok),
        .out_valid (drdy),
        .out_data  (buf_data),
        .front_lvl (front_lvl)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (bus_addr)
                ADDR_CTRL: bus_rdata = WORD_W'(ctrl_q);
                ADDR_STAT: bus_rdata = WORD_W'({seed_err_q, clk_err_q, drdy});
                ADDR_DATA: bus_rdata = read_ok ? buf_data : '0;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq = ctrl_q.ie && (drdy || any_err);
endmodule

// File: rtl/rng_ctrl_chk.sv
module rng_ctrl_chk
    import rng_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned BUF_DEPTH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              seed_err_in,
    input logic              clk_err_in,
    input logic              irq,
    input logic              drdy,
    input logic              seed_err_q,
    input logic              clk_err_q,
    input ctrl_t             ctrl_q,
    input logic [$clog2(BUF_DEPTH+1)-1:0] front_lvl
);
    logic denied_rd, stat_wr;
    assign denied_rd = bus_sel && !bus_wr && (bus_addr == ADDR_DATA)
                       && (!drdy || seed_err_q || clk_err_q);
    assign stat_wr   = bus_sel && bus_wr && (bus_addr == ADDR_STAT);

    AST_DENIED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        denied_rd |-> (bus_rdata == '0)); // R6
    AST_LOCK_FREEZES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.lock |=> (ctrl_q.lock && $stable(ctrl_q.div) && $stable(ctrl_q.ie))); // R10
    AST_CRST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.crst |=> !drdy); // R9
    AST_ERR_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_err_in || clk_err_in) |=> !drdy); // R7
    AST_SEED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_err_q && !stat_wr) |=> seed_err_q); // R7
    AST_CLK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_err_q && !stat_wr) |=> clk_err_q); // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.ie |-> !irq); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        front_lvl <= ($clog2(BUF_DEPTH+1))'(BUF_DEPTH)); // R5
endmodule

bind rng_ctrl rng_ctrl_chk #(.WORD_W(WORD_W), .BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .seed_err_in (seed_err_in),
    .clk_err_in  (clk_err_in),
    .irq         (irq),
    .drdy        (drdy),
    .seed_err_q  (seed_err_q),
    .clk_err_q   (clk_err_q),
    .ctrl_q      (ctrl_q),
    .front_lvl   (front_lvl)
);

// File: tb/tb_rng_ctrl.sv
`timescale 1ns/100ps
module tb_rng_ctrl;
    localparam int INIT = 4;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_sel = 0, bus_wr = 0, ent_valid = 0, seed_err_in = 0, clk_err_in = 0;
    logic [1:0] bus_addr = 0;
    logic [31:0] bus_wdata = 0, ent_data = 0, bus_rdata;
    logic irq;
    int checks = 0, errors = 0;
    logic [31:0] v;

    always #2.5 clk = ~clk;

    rng_ctrl #(.WORD_W(32), .INIT_CYCLES(INIT), .BUF_DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ent_valid(ent_valid), .ent_data(ent_data), .seed_err_in(seed_err_in),
        .clk_err_in(clk_err_in), .irq(irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        ent_valid = 1; ent_data = w;
        @(negedge clk);
        ent_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic soft_reset(input logic [31:0] cfg);
        wr(2'd0, (cfg & 32'hFFFF_FFFA) | 32'h4);
        wr(2'd0, (cfg & 32'hFFFF_FFFB) | 32'h1);
        idle(INIT + 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1;
        idle(2);
        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 stat", v, 0);
        rd(2'd2, v); check("R1 data", v, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R2 field layout: en, ie, div=3
        wr(2'd0, 32'h33);
        rd(2'd0, v); check("R2 ctrl readback", v, 32'h33);

        // R3 word during INIT must be discarded
        push(32'hDEAD_0000);
        idle(INIT + 4);
        for (int k = 0; k < 4; k++) push(32'h100 + k);
        idle(3);
        rd(2'd1, v); check("R4 ready set", v, 32'h1);
        check("R8 irq on ready", {31'd0, irq}, 1);
        for (int k = 0; k < 4; k++) begin
            rd(2'd2, v); check("R3/R4 data order", v, 32'h100 + k);
        end
        rd(2'd1, v); check("R4 ready clear", v, 0);
        check("R8 irq low", {31'd0, irq}, 0);
        rd(2'd2, v); check("R6 empty read", v, 0);

        // R7 seed error
        for (int k = 0; k < 4; k++) push(32'h200 + k);
        idle(3);
        @(negedge clk); seed_err_in = 1; @(negedge clk); seed_err_in = 0;
        rd(2'd1, v); check("R7 seed flag, flushed", v, 32'h4);
        check("R8 irq on error", {31'd0, irq}, 1);
        rd(2'd2, v); check("R6 read during error", v, 0);
        wr(2'd1, 32'h4);
        rd(2'd1, v); check("R7 write 1 keeps", v, 32'h4);
        push(32'hBAD0); idle(2);
        wr(2'd1, 32'h0);
        rd(2'd1, v); check("R7 cleared", v, 0);
        for (int k = 0; k < 4; k++) push(32'h300 + k);
        idle(3);
        rd(2'd2, v); check("R7 data after flush", v, 32'h300);
        // R7 clock error
        @(negedge clk); clk_err_in = 1; @(negedge clk); clk_err_in = 0;
        rd(2'd1, v); check("R7 clock flag", v, 32'h2);
        wr(2'd1, 32'h0);
        rd(2'd1, v); check("R7 clock cleared, flushed", v, 0);

        // R5 sweep over fill counts
        for (int n = 0; n <= 9; n++) begin
            int expn;
            soft_reset(32'h33);
            for (int k = 0; k < n; k++) push((n << 8) + k);
            idle(3);
            expn = (n >= 8) ? 8 : ((n >= 4) ? 4 : 0);
            for (int k = 0; k < expn; k++) begin
                rd(2'd1, v); check("R5 ready held", v, 32'h1);
                rd(2'd2, v); check("R5 word", v, (n << 8) + k);
            end
            rd(2'd1, v); check("R5 ready after drain", v, 0);
        end

        // R9 soft reset with new divider in the same write
        for (int k = 0; k < 4; k++) push(32'h400 + k);
        idle(3);
        wr(2'd0, 32'hA6);
        rd(2'd0, v); check("R9 cfg in reset write", v, 32'hA6);
        rd(2'd1, v); check("R9 flushed", v, 0);
        push(32'hBAD1);
        wr(2'd0, 32'hA3);
        idle(INIT + 4);
        for (int k = 0; k < 4; k++) push(32'h500 + k);
        idle(3);
        for (int k = 0; k < 4; k++) begin
            rd(2'd2, v); check("R9 data after reinit", v, 32'h500 + k);
        end

        // R10 lock
        wr(2'd0, 32'h5B);
        rd(2'd0, v); check("R10 lock set", v, 32'h5B);
        wr(2'd0, 32'h91);
        rd(2'd0, v); check("R10 cfg frozen", v, 32'h5B);
        wr(2'd0, 32'h04);
        rd(2'd0, v); check("R10 crst still works", v, 32'h5E);
        wr(2'd0, 32'h01);
        rd(2'd0, v); check("R10 kept over soft reset", v, 32'h5B);
        @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(1);
        rd(2'd0, v); check("R10 hw reset clears", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule